// File: doc/BRIEF.md
# Count-Based Response Compactor

This block reduces a serial, one-bit response stream from a circuit under test to a small count and compares that count with an expected fault-free value. A start pulse opens a measurement. The block then accepts exactly `STREAM_LEN` qualified response bits, ignoring cycles in which the valid input is low. After the last bit it reports the final count as the signature, raises a done flag, and raises a pass flag when the signature matches the golden input.

Two compaction rules share one counter, and the rule is fixed at start:

- **Ones mode** counts every accepted bit that is 1.
- **Transition mode** keeps the preceding accepted bit in a flip-flop. It counts every accepted bit that differs from that stored bit, so both rising and falling changes add one.

Test control logic uses the block by issuing a start and streaming the response bits. It then reads pass once done is high.

Top module: `ora_count_analyzer`

## Requirements
- R1: After reset, done_o and pass_o are 0 and signature_o is 0. Valid bits offered before the first start leave all three unchanged.
- R2: A start_i pulse clears the count and the bit index and drops done_o. In the cycle after start, signature_o is 0 and done_o is 0. A valid bit offered in the same cycle as start is not accepted.
- R3: With mode_i = 0 (ones mode) at start, the signature equals the number of accepted bits equal to 1.
- R4: With mode_i = 1 (transition mode) at start, the signature equals the number of accepted bits that differ from the previously accepted bit. Changes from 0 to 1 and from 1 to 0 both count.
- R5: In transition mode the first accepted bit of a stream never counts; it only loads the previous-bit register.
- R6: In transition mode the stream 0,1,0,1,1,0,0 (first bit first, STREAM_LEN = 7) yields signature 4.
- R7: Only cycles with bit_valid_i = 1 are accepted. done_o is 0 while the last bit is presented and is 1 in the cycle after the STREAM_LEN-th accepted bit.
- R8: pass_o is 1 exactly when done_o is 1 and signature_o equals golden_i. It is 0 whenever done_o is 0.
- R9: Once done_o is 1, further valid bits are ignored: signature_o and done_o hold until the next start.
- R10: The counter is ceil(log2(STREAM_LEN+1)) bits wide and never wraps within a stream. An all-ones stream in ones mode yields STREAM_LEN.
- R11: Changes on mode_i after the start cycle do not affect the running measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new measurement (one-cycle pulse) |
| mode_i | input | 1 | 0 selects ones counting, 1 selects transition counting; sampled at start |
| bit_valid_i | input | 1 | Qualifies bit_i in this cycle |
| bit_i | input | 1 | Response bit from the circuit under test |
| golden_i | input | CNT_W | Expected fault-free signature |
| signature_o | output | CNT_W | Current or final count |
| done_o | output | 1 | All STREAM_LEN bits consumed |
| pass_o | output | 1 | done_o and signature matches golden_i |

## Verification
Each accepted bit updates the count at the clock edge that samples it. The signature therefore moves one cycle after the bit is offered. done_o rises in the cycle after the last accepted bit, and pass_o follows done_o and golden_i with no further delay.

The bench drives inputs and samples outputs on the falling edge. It checks:

- done_o still low while the final bit is presented, then signature, done and pass one falling edge later;
- a clear signature one cycle after start;
- the held values over several cycles of surplus valid bits after done.

// File: rtl/ora_pkg.sv
package ora_pkg;
    typedef enum logic {
        MODE_ONES  = 1'b0,
        MODE_TRANS = 1'b1
    } ora_mode_e;
endpackage

// File: rtl/ora_seq.sv
module ora_seq #(
    parameter int STREAM_LEN = 7,
    localparam int IDX_W = $clog2(STREAM_LEN + 1)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic bit_valid_i,
    output logic accept_o,
    output logic first_o,
    output logic done_o
);
    typedef struct packed {
        logic             active;
        logic             done;
        logic [IDX_W-1:0] idx;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       last_bit;

    always_comb begin
        st_d     = st_q;
        accept_o = st_q.active && bit_valid_i && !start_i;
        last_bit = accept_o && (st_q.idx == IDX_W'(STREAM_LEN - 1));
        first_o  = (st_q.idx == '0);
        if (start_i) begin
            st_d.active = 1'b1;
            st_d.done   = 1'b0;
            st_d.idx    = '0;
        end else if (accept_o) begin
            st_d.idx = st_q.idx + 1'b1;
            if (last_bit) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;

    assert_done_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.done && !start_i) |=> st_q.done);

    assert_done_after_bit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.done) |-> $past(bit_valid_i));

    assert_idx_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.idx <= IDX_W'(STREAM_LEN));
endmodule

// File: rtl/ora_event.sv
module ora_event
    import ora_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic mode_i,
    input  logic accept_i,
    input  logic first_i,
    input  logic bit_i,
    output logic inc_o,
    output logic mode_trans_o
);
    typedef struct packed {
        ora_mode_e mode;
        logic      prev;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic       changed;

    always_comb begin
        st_d    = st_q;
        changed = (bit_i ^ st_q.prev) && !first_i;
        inc_o   = 1'b0;
        if (accept_i) begin
            inc_o     = (st_q.mode == MODE_TRANS) ? changed : bit_i;
            st_d.prev = bit_i;
        end
        if (start_i) begin
            st_d.mode = ora_mode_e'(mode_i);
            st_d.prev = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_ONES, prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_trans_o = (st_q.mode == MODE_TRANS);

    assert_mode_latched_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> $stable(mode_trans_o));
endmodule

// File: rtl/ora_count.sv
module ora_count #(
    parameter int STREAM_LEN = 7,
    localparam int CNT_W = $clog2(STREAM_LEN + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = '0;
        end else if (inc_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

    assert_no_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= CNT_W'(STREAM_LEN));
endmodule

// File: rtl/ora_count_analyzer.sv
module ora_count_analyzer #(
    parameter int STREAM_LEN = 7,
    localparam int CNT_W = $clog2(STREAM_LEN + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic             bit_valid_i,
    input  logic             bit_i,
    input  logic [CNT_W-1:0] golden_i,
    output logic [CNT_W-1:0] signature_o,
    output logic             done_o,
    output logic             pass_o
);
    logic accept;
    logic first;
    logic inc;
    logic mode_trans;

    ora_seq #(.STREAM_LEN(STREAM_LEN)) seq_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .bit_valid_i(bit_valid_i),
        .accept_o   (accept),
        .first_o    (first),
        .done_o     (done_o)
    );

    ora_event evt_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .accept_i    (accept),
        .first_i     (first),
        .bit_i       (bit_i),
        .inc_o       (inc),
        .mode_trans_o(mode_trans)
    );

    ora_count #(.STREAM_LEN(STREAM_LEN)) cnt_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(start_i),
        .inc_i  (inc),
        .count_o(signature_o)
    );

    assign pass_o = done_o && (signature_o == golden_i);

    assert_pass_needs_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pass_o |-> done_o);

    assert_after_done_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && !start_i) |=> $stable(signature_o));

    assert_first_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && first && mode_trans) |=> $stable(signature_o));

    assert_start_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (signature_o == '0) && !done_o);
endmodule

// File: tb/ora_count_analyzer_tb_top.sv
module ora_count_analyzer_tb_top;
    localparam int L = 7;
    localparam int W = $clog2(L + 1);

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         mode = 1'b0;
    logic         valid = 1'b0;
    logic         bit_in = 1'b0;
    logic [W-1:0] golden = '0;
    logic [W-1:0] sig;
    logic         done;
    logic         pass;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    ora_count_analyzer #(.STREAM_LEN(L)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .start_i    (start),
        .mode_i     (mode),
        .bit_valid_i(valid),
        .bit_i      (bit_in),
        .golden_i   (golden),
        .signature_o(sig),
        .done_o     (done),
        .pass_o     (pass)
    );

    function automatic int ones_of(input logic [L-1:0] s);
        int c = 0;
        for (int i = 0; i < L; i++) c += int'(s[i]);
        return c;
    endfunction

    function automatic int trans_of(input logic [L-1:0] s);
        int c = 0;
        for (int i = 1; i < L; i++) if (s[i] != s[i-1]) c++;
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // s[0] is the first bit of the stream
    task automatic run_stream(input logic [L-1:0] s, input logic m, input bit flip_mode,
                              input bit bad_golden, input int gap_max, input string req);
        int exp;
        exp = m ? trans_of(s) : ones_of(s);
        @(negedge clk);
        start  = 1'b1;
        mode   = m;
        valid  = 1'b1;
        bit_in = 1'b1;
        golden = bad_golden ? W'(exp + 1) : W'(exp);
        @(negedge clk);
        start = 1'b0;
        valid = 1'b0;
        check(sig == '0 && !done, "R2 start clears", int'(sig), 0);
        for (int i = 0; i < L; i++) begin
            int gaps = (gap_max > 0) ? int'($urandom % (gap_max + 1)) : 0;
            for (int g = 0; g < gaps; g++) begin
                valid  = 1'b0;
                bit_in = 1'($urandom);
                if (flip_mode) mode = ~mode;
                @(negedge clk);
            end
            valid  = 1'b1;
            bit_in = s[i];
            if (flip_mode) mode = ~mode;
            if (i == L - 1) check(!done, "R7 done low at last bit", int'(done), 0);
            @(negedge clk);
        end
        valid = 1'b0;
        check(done, "R7 done after last bit", int'(done), 1);
        check(int'(sig) == exp, req, int'(sig), exp);
        check(pass == !bad_golden, "R8 pass compare", int'(pass), int'(!bad_golden));
        for (int k = 0; k < 3; k++) begin
            valid  = 1'b1;
            bit_in = ~bit_in;
            @(negedge clk);
        end
        valid = 1'b0;
        check(int'(sig) == exp && done, "R9 bits after done ignored", int'(sig), exp);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check(!done && !pass && sig == '0, "R1 reset state", int'(sig), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            valid  = 1'b1;
            bit_in = 1'b1;
            @(negedge clk);
        end
        valid = 1'b0;
        check(!done && sig == '0, "R1 idle bits ignored", int'(sig), 0);
        check(!pass, "R8 pass low when not done", int'(pass), 0);

        run_stream(7'b0011010, 1'b1, 1'b0, 1'b0, 0, "R6 stream 0101100 transitions");
        run_stream(7'b1111111, 1'b1, 1'b0, 1'b0, 2, "R5 first bit not a transition");
        run_stream(7'b0000001, 1'b1, 1'b0, 1'b0, 1, "R5 lone first one not counted");
        run_stream(7'b1111111, 1'b0, 1'b0, 1'b0, 0, "R10 all ones no wrap");
        run_stream(7'b1010101, 1'b1, 1'b0, 1'b1, 0, "R4 alternating transitions");
        run_stream(7'b0000000, 1'b0, 1'b0, 1'b0, 3, "R3 all zeros");
        run_stream(7'b0110110, 1'b0, 1'b1, 1'b0, 2, "R11 mode change ignored ones");
        run_stream(7'b0110110, 1'b1, 1'b1, 1'b0, 2, "R11 mode change ignored trans");

        for (int t = 0; t < 40; t++) begin
            logic [L-1:0] s = L'($urandom);
            logic         m = 1'($urandom);
            if (m) run_stream(s, m, 1'($urandom), 1'($urandom), 3, "R4 random transitions");
            else   run_stream(s, m, 1'($urandom), 1'($urandom), 3, "R3 random ones");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule